// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns an instruction's memory offset into a linear address. It adds the offset to the base of one of six segment registers: code, data, stack, extra, and two more data segments. Each request carries three things: the offset, a default segment code that the instruction class picks, and an optional prefix byte. A prefix byte can replace the default segment with another one. The block registers the result, so the address and the segment actually used appear one cycle after the request.

Segment registers are loaded through a write port. Each write carries a 16-bit segment value and a 32-bit shadow base. The mode input selects how the base is formed:

- **Protected mode (mode high):** the shadow base is added to the offset, and the sum wraps at 2^32.
- **Real mode (mode low):** the 16-bit segment value shifted left by four is added to the offset, and the sum wraps at 2^20.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset no response is valid, and every segment value and shadow base is zero, so a request made before any write returns the offset itself as its address (protected mode) and the offset modulo 2^20 (real mode).
- R2: A request accepted at a clock edge gives `rsp_valid_o` high for exactly the following cycle. No response appears without a request.
- R3: In protected mode (`prot_mode_i`=1) the address is the chosen segment's shadow base plus the offset, modulo 2^32.
- R4: In real mode (`prot_mode_i`=0) the address is (segment value × 16) + offset, modulo 2^20, and bits 31:20 of the address are zero.
- R5: Segment codes are CS=0, DS=1, SS=2, ES=3, FS=4, GS=5. Without an override, the default code is used. Default codes 6 and 7 fall back to DS.
- R6: A valid prefix byte 0x26 selects ES, whatever the default.
- R7: Valid prefix bytes 0x2E, 0x36, 0x3E, 0x64 and 0x65 select CS, SS, DS, FS and GS respectively.
- R8: Any other prefix value, or any prefix with `req_pfx_valid_i` low, leaves the default segment in force.
- R9: A write with `wr_en_i` high and a code of 0 to 5 replaces that segment's value and base, and the change is seen from the next cycle's request onward. A request made in the same cycle as the write uses the old contents. Writes with codes 6 or 7 change nothing.
- R10: `rsp_seg_o` reports the code of the segment whose base formed the address.
- R11: While no request is present, `rsp_addr_o` and `rsp_seg_o` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_mode_i | input | 1 | 1 = protected mode, 0 = real mode |
| wr_en_i | input | 1 | Segment register write strobe |
| wr_seg_i | input | 3 | Segment code to write |
| wr_sel_i | input | 16 | Segment value to store |
| wr_base_i | input | 32 | Shadow base to store |
| req_valid_i | input | 1 | Address request present |
| req_offset_i | input | 32 | Instruction offset |
| req_dflt_seg_i | input | 3 | Default segment code for the instruction class |
| req_pfx_valid_i | input | 1 | A prefix byte accompanies the request |
| req_pfx_i | input | 8 | Prefix byte value |
| rsp_valid_o | output | 1 | Registered response valid |
| rsp_addr_o | output | 32 | Linear address |
| rsp_seg_o | output | 3 | Segment code used |

## Verification
A corrupted segment register shows up on the very next request that selects it. The response one cycle later carries a wrong address, while its segment code is still right. That pairing separates storage faults from selection faults.

A fault in prefix decoding or in the default fallback shows up as a wrong `rsp_seg_o`. It also usually gives a wrong address in the same response cycle, because every segment is loaded with a distinct value and base.

Wrong wrap handling only shows when a sum crosses 2^20 or 2^32, so those crossings are driven on purpose in both modes.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    parameter int NUM_SEG = 6;
    parameter int SEG_W   = 3;
    parameter int PFX_W   = 8;

    typedef enum logic [SEG_W-1:0] {
        SEG_CS = 3'd0,
        SEG_DS = 3'd1,
        SEG_SS = 3'd2,
        SEG_ES = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_e;

    // Override byte that forces each segment, indexed by segment code.
    function automatic logic [PFX_W-1:0] pfx_code(input int idx);
        logic [PFX_W-1:0] code;
        case (idx)
            0:       code = 8'h2E;
            1:       code = 8'h3E;
            2:       code = 8'h36;
            3:       code = 8'h26;
            4:       code = 8'h64;
            default: code = 8'h65;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/seg_prefix_decode.sv
module seg_prefix_decode
    import seg_addr_pkg::*;
(
    input  logic [SEG_W-1:0] dflt_seg_i,
    input  logic             pfx_valid_i,
    input  logic [PFX_W-1:0] pfx_i,
    output logic [SEG_W-1:0] seg_o
);

    logic [NUM_SEG-1:0] pfx_hit;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SEG; gi++) begin : g_hit
            assign pfx_hit[gi] = pfx_valid_i && (pfx_i == pfx_code(gi));
        end
    endgenerate

    always_comb begin
        if (dflt_seg_i < SEG_W'(NUM_SEG)) begin
            seg_o = dflt_seg_i;
        end else begin
            seg_o = SEG_DS;
        end
        for (int i = 0; i < NUM_SEG; i++) begin
            if (pfx_hit[i]) begin
                seg_o = SEG_W'(i);
            end
        end
    end

endmodule

// File: rtl/seg_base_file.sv
module seg_base_file
    import seg_addr_pkg::*;
#(
    parameter int SEL_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SEG_W-1:0]  wr_seg_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [ADDR_W-1:0] wr_base_i,
    input  logic [SEG_W-1:0]  rd_seg_i,
    output logic [SEL_W-1:0]  rd_sel_o,
    output logic [ADDR_W-1:0] rd_base_o
);

    typedef struct packed {
        logic [NUM_SEG-1:0][SEL_W-1:0]  sel;
        logic [NUM_SEG-1:0][ADDR_W-1:0] base;
    } bank_t;

    bank_t              bank_d, bank_q;
    logic [NUM_SEG-1:0] wr_hit;

    genvar gs;
    generate
        for (gs = 0; gs < NUM_SEG; gs++) begin : g_wr
            assign wr_hit[gs] = wr_en_i && (wr_seg_i == SEG_W'(gs));
        end
    endgenerate

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (wr_hit[i]) begin
                bank_d.sel[i]  = wr_sel_i;
                bank_d.base[i] = wr_base_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rd_sel_o  = '0;
        rd_base_o = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (rd_seg_i == SEG_W'(i)) begin
                rd_sel_o  = bank_q.sel[i];
                rd_base_o = bank_q.base[i];
            end
        end
    end

endmodule

// File: rtl/seg_linear_adder.sv
module seg_linear_adder #(
    parameter int SEL_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int REAL_SHIFT = 4
) (
    input  logic              prot_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] offset_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int REAL_AW = SEL_W + REAL_SHIFT;

    logic [REAL_AW-1:0] real_base;
    logic [REAL_AW-1:0] real_sum;
    logic [ADDR_W-1:0]  prot_sum;

    assign real_base = {sel_i, {REAL_SHIFT{1'b0}}};
    assign real_sum  = real_base + offset_i[REAL_AW-1:0];
    assign prot_sum  = base_i + offset_i;

    always_comb begin
        if (prot_i) begin
            addr_o = prot_sum;
        end else begin
            addr_o = {{(ADDR_W-REAL_AW){1'b0}}, real_sum};
        end
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEL_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int REAL_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_mode_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_seg_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [ADDR_W-1:0] wr_base_i,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_offset_i,
    input  logic [2:0]        req_dflt_seg_i,
    input  logic              req_pfx_valid_i,
    input  logic [7:0]        req_pfx_i,
    output logic              rsp_valid_o,
    output logic [ADDR_W-1:0] rsp_addr_o,
    output logic [2:0]        rsp_seg_o
);

    localparam int REAL_AW = SEL_W + REAL_SHIFT;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [SEG_W-1:0]  seg;
    } rsp_t;

    rsp_t              rsp_d, rsp_q;
    logic [SEG_W-1:0]  eff_seg;
    logic [SEL_W-1:0]  eff_sel;
    logic [ADDR_W-1:0] eff_base;
    logic [ADDR_W-1:0] lin_addr;

    seg_prefix_decode u_decode (
        .dflt_seg_i  (req_dflt_seg_i),
        .pfx_valid_i (req_pfx_valid_i),
        .pfx_i       (req_pfx_i),
        .seg_o       (eff_seg)
    );

    seg_base_file #(
        .SEL_W  (SEL_W),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_seg_i  (wr_seg_i),
        .wr_sel_i  (wr_sel_i),
        .wr_base_i (wr_base_i),
        .rd_seg_i  (eff_seg),
        .rd_sel_o  (eff_sel),
        .rd_base_o (eff_base)
    );

    seg_linear_adder #(
        .SEL_W      (SEL_W),
        .ADDR_W     (ADDR_W),
        .REAL_SHIFT (REAL_SHIFT)
    ) u_adder (
        .prot_i   (prot_mode_i),
        .sel_i    (eff_sel),
        .base_i   (eff_base),
        .offset_i (req_offset_i),
        .addr_o   (lin_addr)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid_i;
        if (req_valid_i) begin
            rsp_d.addr = lin_addr;
            rsp_d.seg  = eff_seg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid_o = rsp_q.valid;
    assign rsp_addr_o  = rsp_q.addr;
    assign rsp_seg_o   = rsp_q.seg;

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);  // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !rsp_valid_o);  // R2
    AST_REAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !prot_mode_i) |=> (rsp_addr_o[ADDR_W-1:REAL_AW] == '0));  // R4
    AST_DEFAULT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_pfx_valid_i && (req_dflt_seg_i < 3'd6))
            |=> (rsp_seg_o == $past(req_dflt_seg_i)));  // R5
    AST_ES_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_pfx_valid_i && (req_pfx_i == 8'h26))
            |=> (rsp_seg_o == SEG_ES));  // R6
    AST_SEG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (rsp_seg_o < 3'd6));  // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> ($stable(rsp_addr_o) && $stable(rsp_seg_o)));  // R11

endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        prot_mode_i;
    logic        wr_en_i;
    logic [2:0]  wr_seg_i;
    logic [15:0] wr_sel_i;
    logic [31:0] wr_base_i;
    logic        req_valid_i;
    logic [31:0] req_offset_i;
    logic [2:0]  req_dflt_seg_i;
    logic        req_pfx_valid_i;
    logic [7:0]  req_pfx_i;
    logic        rsp_valid_o;
    logic [31:0] rsp_addr_o;
    logic [2:0]  rsp_seg_o;

    always #10 clk = ~clk;

    seg_addr_gen u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .prot_mode_i     (prot_mode_i),
        .wr_en_i         (wr_en_i),
        .wr_seg_i        (wr_seg_i),
        .wr_sel_i        (wr_sel_i),
        .wr_base_i       (wr_base_i),
        .req_valid_i     (req_valid_i),
        .req_offset_i    (req_offset_i),
        .req_dflt_seg_i  (req_dflt_seg_i),
        .req_pfx_valid_i (req_pfx_valid_i),
        .req_pfx_i       (req_pfx_i),
        .rsp_valid_o     (rsp_valid_o),
        .rsp_addr_o      (rsp_addr_o),
        .rsp_seg_o       (rsp_seg_o)
    );

    typedef struct {
        logic [31:0] addr;
        logic [2:0]  seg;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    logic [15:0] m_sel [6];
    logic [31:0] m_base [6];
    logic [31:0] last_addr = '0;
    logic [2:0]  last_seg = '0;
    bit          done = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] pick_seg(input logic [2:0] dflt, input bit pv, input logic [7:0] pfx);
        logic [2:0] s;
        s = (dflt > 3'd5) ? 3'd1 : dflt;
        if (pv) begin
            case (pfx)
                8'h2E: s = 3'd0;
                8'h3E: s = 3'd1;
                8'h36: s = 3'd2;
                8'h26: s = 3'd3;
                8'h64: s = 3'd4;
                8'h65: s = 3'd5;
                default: ;
            endcase
        end
        return s;
    endfunction

    task automatic tick();
        @(negedge clk);
        wr_en_i         = 1'b0;
        req_valid_i     = 1'b0;
        req_pfx_valid_i = 1'b0;
    endtask

    task automatic drive_req(input logic [31:0] off, input logic [2:0] dflt, input bit pv,
                             input logic [7:0] pfx, input string tag);
        exp_t       e;
        logic [2:0] s;
        logic [19:0] rs;
        s = pick_seg(dflt, pv, pfx);
        if (prot_mode_i) begin
            e.addr = m_base[s] + off;
        end else begin
            rs = {m_sel[s], 4'h0} + off[19:0];
            e.addr = {12'h000, rs};
        end
        e.seg = s;
        e.tag = tag;
        sb.push_back(e);
        req_valid_i     = 1'b1;
        req_offset_i    = off;
        req_dflt_seg_i  = dflt;
        req_pfx_valid_i = pv;
        req_pfx_i       = pfx;
    endtask

    task automatic drive_wr(input logic [2:0] s, input logic [15:0] sel, input logic [31:0] base);
        wr_en_i   = 1'b1;
        wr_seg_i  = s;
        wr_sel_i  = sel;
        wr_base_i = base;
        if (s < 3'd6) begin
            m_sel[s]  = sel;
            m_base[s] = base;
        end
    endtask

    // Monitor: responses are sampled 2 ns after the edge that registers them.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && !done) begin
                if (sb.size() > 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rsp_valid_o === 1'b1, {"R2 valid ", e.tag}, 32'(rsp_valid_o), 32'd1);
                    check(rsp_addr_o === e.addr, {"addr ", e.tag}, rsp_addr_o, e.addr);
                    check(rsp_seg_o === e.seg, {"R10 seg ", e.tag}, 32'(rsp_seg_o), 32'(e.seg));
                end else begin
                    check(rsp_valid_o === 1'b0, "R2 no spurious response", 32'(rsp_valid_o), 32'd0);
                    check(rsp_addr_o === last_addr && rsp_seg_o === last_seg,
                          "R11 hold while idle", rsp_addr_o, last_addr);
                end
                last_addr = rsp_addr_o;
                last_seg  = rsp_seg_o;
            end
        end
    end

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) begin
            m_sel[i]  = '0;
            m_base[i] = '0;
        end
        rst_n = 1'b0;
        prot_mode_i = 1'b1;
        wr_en_i = 1'b0; wr_seg_i = '0; wr_sel_i = '0; wr_base_i = '0;
        req_valid_i = 1'b0; req_offset_i = '0; req_dflt_seg_i = '0;
        req_pfx_valid_i = 1'b0; req_pfx_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        check(rsp_valid_o === 1'b0, "R1 reset valid low", 32'(rsp_valid_o), 32'd0);

        // R1: zero bases after reset
        drive_req(32'h0000_1234, 3'd1, 0, 8'h00, "R1 prot zero base"); tick();
        prot_mode_i = 1'b0;
        drive_req(32'h0012_3456, 3'd2, 0, 8'h00, "R1 real zero base"); tick();
        prot_mode_i = 1'b1;

        // R9: load all six segments with distinct contents
        for (int i = 0; i < 6; i++) begin
            drive_wr(3'(i), 16'h1000 + 16'(i * 16'h0111), 32'h0001_0000 * (i + 1));
            tick();
        end
        drive_wr(3'd1, 16'h0050, 32'h0000_0500); tick();
        drive_wr(3'd3, 16'h0350, 32'h0000_3500); tick();

        // R3: worked examples
        drive_req(32'h10, 3'd1, 0, 8'h00, "R3 DS 0x510"); tick();
        drive_req(32'h10, 3'd1, 1, 8'h26, "R6 ES 0x3510"); tick();

        // R5: each default, back to back
        for (int i = 0; i < 8; i++) begin
            drive_req(32'h0000_0100 + 32'(i), 3'(i), 0, 8'h00, "R5 default");
            tick();
        end

        // R6, R7: overrides against a GS default
        drive_req(32'h44, 3'd5, 1, 8'h26, "R6 ES over GS"); tick();
        drive_req(32'h44, 3'd5, 1, 8'h2E, "R7 CS"); tick();
        drive_req(32'h44, 3'd5, 1, 8'h36, "R7 SS"); tick();
        drive_req(32'h44, 3'd0, 1, 8'h3E, "R7 DS"); tick();
        drive_req(32'h44, 3'd0, 1, 8'h64, "R7 FS"); tick();
        drive_req(32'h44, 3'd0, 1, 8'h65, "R7 GS"); tick();

        // R8: non-override prefixes
        drive_req(32'h48, 3'd2, 1, 8'h2F, "R8 bad prefix"); tick();
        drive_req(32'h48, 3'd4, 1, 8'hF0, "R8 lock-like prefix"); tick();
        drive_req(32'h48, 3'd0, 0, 8'h26, "R8 prefix not valid"); tick();

        // Idle gap for R11
        tick(); tick();

        // R3: protected wrap
        drive_wr(3'd4, 16'hABCD, 32'hFFFF_FFF0); tick();
        drive_req(32'h20, 3'd4, 0, 8'h00, "R3 wrap 2^32"); tick();

        // R4: real mode
        prot_mode_i = 1'b0;
        drive_wr(3'd1, 16'h1234, 32'hDEAD_0000); tick();
        drive_req(32'h5678, 3'd1, 0, 8'h00, "R4 real sum"); tick();
        drive_wr(3'd2, 16'hFFFF, 32'h0); tick();
        drive_req(32'h20, 3'd2, 0, 8'h00, "R4 wrap 2^20"); tick();
        drive_req(32'hFFFF_FFFF, 3'd2, 0, 8'h00, "R4 large offset"); tick();
        prot_mode_i = 1'b1;

        // R9: same-cycle write is not seen; next request sees it
        drive_req(32'h8, 3'd5, 0, 8'h00, "R9 same cycle old base");
        drive_wr(3'd5, 16'h7777, 32'h7000_0000);
        tick();
        drive_req(32'h8, 3'd5, 0, 8'h00, "R9 new base"); tick();

        // R9: codes 6 and 7 change nothing
        drive_wr(3'd6, 16'h9999, 32'h9999_9999); tick();
        drive_wr(3'd7, 16'h8888, 32'h8888_8888); tick();
        for (int i = 0; i < 6; i++) begin
            drive_req(32'h3, 3'(i), 0, 8'h00, "R9 illegal write ignored");
            tick();
        end
        prot_mode_i = 1'b0;
        for (int i = 0; i < 6; i++) begin
            drive_req(32'h3, 3'(i), 0, 8'h00, "R9 illegal write ignored real");
            tick();
        end

        repeat (3) tick();
        done = 1;
        check(sb.size() == 0, "R2 all responses seen", 32'(sb.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule